// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block runs on the host side of a parallel flash device. After the host has written a program or erase command sequence, it starts the poller. The start carries the bit the device will show on data bit 7 once the operation is complete: the programmed value of bit 7 for a program, or 1 for an erase. It also carries the address to poll, which is the programmed location or any location inside a sector being erased. The poller then reads the device over a simple request/acknowledge read port until the operation resolves.

A byte whose bit 7 shows the true value ends polling successfully. Because bit 7 may settle before the lower bits, the byte reported to the host comes from one further, separate read. Bit 5 set with bit 7 still complemented means the device flagged an internal timeout. Since the two bits can change together, the poller reads once more and decides on that second look. A cycle limit, latched at start, bounds the whole poll.

Top module: `dpoll_checker`

## Requirements
- R1: While reset is held, and after it until a start is accepted, `rd_req_o`, `done_o`, `pass_o`, `fail_o` and `tmo_o` are 0 and `data_o` is 0.
- R2: Every read request presents on `rd_addr_o` the address latched when the start was accepted, unchanged for the whole poll.
- R3: A poll read whose bit 7 equals the expected bit is followed by exactly one more read. One cycle after that read is acknowledged, `done_o` and `pass_o` pulse and `data_o` holds the byte it returned.
- R4: A poll read with bit 7 unequal to the expected bit and bit 5 clear is followed by another poll read, with the request kept high. This repeats until some other rule ends the poll.
- R5: A poll read with bit 7 unequal and bit 5 set is followed by exactly one re-read. If bit 7 now matches, R3 applies. Otherwise `done_o` and `fail_o` pulse one cycle after that acknowledge, `tmo_o` stays 0 and no further read is issued.
- R6: Number the cycles of the polling phase (poll reads and the re-read) from 0, starting the cycle after the start is accepted. If cycle L, where L is `limit_i` latched at start, has no acknowledged read, polling stops. `done_o`, `fail_o` and `tmo_o` then pulse in the next cycle. An acknowledge in that cycle takes precedence, and the final data read is not limited.
- R7: A start pulse while a poll is active is ignored: address, expected bit and limit keep their accepted values.
- R8: `pass_o` and `fail_o` are never high together, each is high only together with `done_o`, and `done_o` is high for a single cycle per poll.
- R9: The expected bit is taken from `expect_i` at start. With expected 0, a byte with bit 7 = 0 passes and a byte with bit 7 = 1 is a mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| expect_i | input | 1 | Value bit 7 takes when the operation is complete |
| addr_i | input | ADDR_W | Address to poll |
| limit_i | input | CNT_W | Polling cycle limit L |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | 8 | Byte returned by the device |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed successfully (with done) |
| fail_o | output | 1 | Operation failed (with done) |
| tmo_o | output | 1 | Failure caused by the cycle limit (with done) |
| data_o | output | 8 | Byte from the read after the pass decision |

## Verification
The poller is driven with an immediate bit 7 match and with streams of mismatching bytes that have bit 5 clear. These show that matching ends polling only through an extra data read, and that the final byte comes from that later read. Bit 5 set is tried once with a matching re-read and once with a mismatching one, which tells the second look apart from an instant failure. Limits are exercised with no acknowledge at all, with steady mismatches, and with a zero limit met by an immediate acknowledge, so that timeout precedence is pinned down. A start pulse in mid-poll with a different address, polarity and zero limit shows that nothing already accepted is disturbed.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  localparam int unsigned DP_BYTE_W   = 8;
  localparam int unsigned DP_TRUE_BIT = 7;
  localparam int unsigned DP_TOUT_BIT = 5;

  typedef logic [DP_BYTE_W-1:0] dp_byte_t;

  typedef enum logic [1:0] {
    DP_IDLE  = 2'd0,
    DP_POLL  = 2'd1,
    DP_RECHK = 2'd2,
    DP_FINAL = 2'd3
  } dp_phase_e;

  // bit 7 shows the true datum once the operation is over
  function automatic logic dp_bit7_true(input dp_byte_t b, input logic exp_bit);
    return b[DP_TRUE_BIT] == exp_bit;
  endfunction

  // bit 5 flags that the device's internal limit was exceeded
  function automatic logic dp_dev_tout(input dp_byte_t b);
    return b[DP_TOUT_BIT];
  endfunction

  function automatic logic dp_limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/dpoll_timer.sv
module dpoll_timer
  import dpoll_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (run_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && !ack_i &&
                     dp_limit_hit(32'(cnt_q), 32'(lim_q));
endmodule

// File: rtl/dpoll_fsm.sv
module dpoll_fsm
  import dpoll_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              expect_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  input  dp_byte_t          data_i,
  input  logic              expired_i,
  output dp_phase_e         phase_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              accept_o,
  output logic              ack_o,
  output logic              match_o,
  output logic              pass_ev_o,
  output logic              fail_ev_o
);
  dp_phase_e         ph_q, ph_d;
  logic              exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic              tflag;

  assign rd_req_o  = (ph_q != DP_IDLE);
  assign rd_addr_o = addr_q;
  assign phase_o   = ph_q;
  assign accept_o  = (ph_q == DP_IDLE) && start_i;
  assign ack_o     = rd_req_o && ack_i;
  assign match_o   = dp_bit7_true(data_i, exp_q);
  assign tflag     = dp_dev_tout(data_i);

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      DP_IDLE:  if (start_i) ph_d = DP_POLL;
      DP_POLL: begin
        if (ack_o) begin
          if (match_o)    ph_d = DP_FINAL;
          else if (tflag) ph_d = DP_RECHK;
        end else if (expired_i) begin
          ph_d = DP_IDLE;
        end
      end
      DP_RECHK: begin
        if (ack_o)          ph_d = match_o ? DP_FINAL : DP_IDLE;
        else if (expired_i) ph_d = DP_IDLE;
      end
      DP_FINAL: if (ack_o) ph_d = DP_IDLE;
      default:  ph_d = DP_IDLE;
    endcase
  end

  assign pass_ev_o = (ph_q == DP_FINAL) && ack_o;
  assign fail_ev_o = ((ph_q == DP_RECHK) && ack_o && !match_o) || expired_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= DP_IDLE;
      exp_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept_o) begin
        exp_q  <= expect_i;
        addr_q <= addr_i;
      end
    end
  end
endmodule

// File: rtl/dpoll_result.sv
module dpoll_result
  import dpoll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pass_ev_i,
  input  logic     fail_ev_i,
  input  logic     tmo_ev_i,
  input  dp_byte_t data_i,
  output logic     done_o,
  output logic     pass_o,
  output logic     fail_o,
  output logic     tmo_o,
  output dp_byte_t data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      tmo_o  <= 1'b0;
      data_o <= '0;
    end else begin
      done_o <= pass_ev_i || fail_ev_i;
      pass_o <= pass_ev_i;
      fail_o <= fail_ev_i && !pass_ev_i;
      tmo_o  <= tmo_ev_i && !pass_ev_i;
      if (pass_ev_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker
  import dpoll_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              expect_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  limit_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              tmo_o,
  output logic [7:0]        data_o
);
  dp_phase_e phase_w;
  logic      accept_w;
  logic      ack_w;
  logic      match_w;
  logic      expired_w;
  logic      pass_ev_w;
  logic      fail_ev_w;
  logic      polling_w;
  logic      recheck_w;

  assign polling_w = (phase_w == DP_POLL) || (phase_w == DP_RECHK);
  assign recheck_w = (phase_w == DP_RECHK);

  dpoll_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .expect_i  (expect_i),
    .addr_i    (addr_i),
    .ack_i     (rd_ack_i),
    .data_i    (rd_data_i),
    .expired_i (expired_w),
    .phase_o   (phase_w),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .accept_o  (accept_w),
    .ack_o     (ack_w),
    .match_o   (match_w),
    .pass_ev_o (pass_ev_w),
    .fail_ev_o (fail_ev_w)
  );

  dpoll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (accept_w),
    .run_i     (polling_w),
    .ack_i     (ack_w),
    .limit_i   (limit_i),
    .expired_o (expired_w)
  );

  dpoll_result u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass_ev_i (pass_ev_w),
    .fail_ev_i (fail_ev_w),
    .tmo_ev_i  (expired_w),
    .data_i    (rd_data_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .tmo_o     (tmo_o),
    .data_o    (data_o)
  );
endmodule

// File: rtl/dpoll_props.sv
module dpoll_props #(
  parameter int unsigned ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic              tmo_o,
  input logic              ack_w,
  input logic              recheck_w,
  input logic              match_w,
  input logic              expired_w
);
  // R8
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  // R8
  result_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |-> done_o);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && rd_req_o) |=> $stable(rd_addr_o));

  // R5
  recheck_miss_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recheck_w && ack_w && !match_w) |=> (fail_o && !tmo_o));

  // R6
  expiry_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired_w |=> (fail_o && tmo_o));

  // R3
  pass_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> $past(ack_w));
endmodule

bind dpoll_checker dpoll_props #(.ADDR_W(ADDR_W)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .done_o    (done_o),
  .pass_o    (pass_o),
  .fail_o    (fail_o),
  .tmo_o     (tmo_o),
  .ack_w     (ack_w),
  .recheck_w (recheck_w),
  .match_w   (match_w),
  .expired_w (expired_w)
);

// File: tb/dpoll_checker_test.sv
module dpoll_checker_test;
  localparam int ADDR_W = 21;
  localparam int CNT_W  = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              expect_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [CNT_W-1:0]  limit_i = '0;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rd_ack_i = 1'b0;
  logic [7:0]        rd_data_i = 8'h00;
  logic              done_o, pass_o, fail_o, tmo_o;
  logic [7:0]        data_o;

  always #5 clk = ~clk;

  dpoll_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .expect_i(expect_i),
    .addr_i(addr_i), .limit_i(limit_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .tmo_o(tmo_o),
    .data_o(data_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device responder
  logic [7:0] byte_q[$];
  logic [7:0] dflt_byte = 8'h00;
  int ack_dly = 0;
  int wait_n = 0;
  int n_reads = 0;

  // behavioural reference
  int         m_ph = 0;
  int         m_cnt = 0;
  int         m_lim = 0;
  logic       m_exp = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic       m_done = 0, m_pass = 0, m_fail = 0, m_tmo = 0;
  logic [7:0] m_data = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_lim = 0; m_exp = 0; m_addr = '0;
      m_done = 0; m_pass = 0; m_fail = 0; m_tmo = 0; m_data = 8'h00;
    end else begin
      bit ackd;
      ackd = rd_ack_i && (m_ph != 0);
      m_done = 0; m_pass = 0; m_fail = 0; m_tmo = 0;
      if (m_ph == 0) begin
        if (start_i) begin
          m_ph = 1; m_cnt = 0; m_lim = int'(limit_i);
          m_exp = expect_i; m_addr = addr_i;
        end
      end else if (m_ph == 3) begin
        if (ackd) begin
          m_ph = 0; m_done = 1; m_pass = 1; m_data = rd_data_i;
        end
      end else begin
        if (ackd) begin
          if (rd_data_i[7] == m_exp) m_ph = 3;
          else if (m_ph == 2) begin m_ph = 0; m_done = 1; m_fail = 1; end
          else if (rd_data_i[5]) m_ph = 2;
        end else if (m_cnt >= m_lim) begin
          m_ph = 0; m_done = 1; m_fail = 1; m_tmo = 1;
        end
        m_cnt++;
      end
    end
  end

  int n_done = 0;
  logic l_pass = 0, l_fail = 0, l_tmo = 0;
  logic [7:0] l_data = 8'h00;

  always @(negedge clk) begin
    // compare against the reference
    if (!rst_n) begin
      chk(rd_req_o == 0 && done_o == 0 && pass_o == 0 && fail_o == 0 &&
          tmo_o == 0 && data_o == 0, "R1 reset state", {rd_req_o, done_o, pass_o, fail_o, tmo_o}, 0);
    end else begin
      chk(rd_req_o == (m_ph != 0), "R4 read request", rd_req_o, m_ph != 0);
      if (rd_req_o) chk(rd_addr_o == m_addr, "R2 R7 poll address", rd_addr_o, m_addr);
      chk(done_o == m_done && pass_o == m_pass && fail_o == m_fail, "R8 result pulses",
          {done_o, pass_o, fail_o}, {m_done, m_pass, m_fail});
      chk(tmo_o == m_tmo, "R6 timeout flag", tmo_o, m_tmo);
      chk(data_o == m_data, "R3 final data", data_o, m_data);
      if (done_o) begin
        n_done++; l_pass = pass_o; l_fail = fail_o; l_tmo = tmo_o; l_data = data_o;
      end
    end
    // responder
    rd_ack_i = 1'b0;
    rd_data_i = 8'h00;
    if (rd_req_o && ack_dly >= 0) begin
      if (wait_n >= ack_dly) begin
        rd_ack_i = 1'b1;
        rd_data_i = (byte_q.size() > 0) ? byte_q.pop_front() : dflt_byte;
        wait_n = 0;
        n_reads++;
      end else begin
        wait_n++;
      end
    end else begin
      wait_n = 0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic pulse_start(input logic [ADDR_W-1:0] a, input logic e, input int lim);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; expect_i = e; limit_i = CNT_W'(lim);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 400 && n_done == d0; i++) @(negedge clk);
    @(negedge clk);
    chk(n_done == d0 + 1, "R8 one done per poll", n_done, d0 + 1);
  endtask

  task automatic run_op(input logic [ADDR_W-1:0] a, input logic e, input int lim);
    int d0;
    d0 = n_done;
    n_reads = 0;
    pulse_start(a, e, lim);
    wait_done(d0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_req_o == 0 && data_o == 0, "R1 idle during reset", rd_req_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_req_o == 0 && done_o == 0, "R1 idle after reset", rd_req_o, 0);

    // R4 R3: mismatches with bit5 clear, then match, then data read
    byte_q = {8'h05, 8'h05, 8'h85, 8'hA5};
    ack_dly = 2;
    run_op(21'h01234, 1'b1, 1000);
    chk(l_pass && !l_fail, "R3 pass after match", l_pass, 1);
    chk(l_data == 8'hA5, "R3 data from later read", l_data, 8'hA5);
    chk(n_reads == 4, "R4 three polls plus data read", n_reads, 4);

    // R5: bit5 set, re-read matches
    byte_q = {8'h20, 8'h80, 8'hFF};
    ack_dly = 0;
    run_op(21'h1F000, 1'b1, 1000);
    chk(l_pass && !l_tmo, "R5 re-read match passes", l_pass, 1);
    chk(l_data == 8'hFF, "R5 data after re-read", l_data, 8'hFF);
    chk(n_reads == 3, "R5 read count on recovery", n_reads, 3);

    // R5 R9: expected 0, bit5 set, re-read mismatch
    byte_q = {8'h80, 8'hA0, 8'hA0};
    ack_dly = 1;
    run_op(21'h00777, 1'b0, 1000);
    chk(l_fail && !l_pass && !l_tmo, "R5 re-read mismatch fails", l_fail, 1);
    repeat (5) @(negedge clk);
    chk(n_reads == 3, "R5 no read after failure", n_reads, 3);

    // R9: expected 0 passes on bit7 clear
    byte_q = {8'h80, 8'h7F, 8'h42};
    ack_dly = 0;
    run_op(21'h00100, 1'b0, 1000);
    chk(l_pass && l_data == 8'h42, "R9 expected zero passes", l_data, 8'h42);

    // R6: no acknowledge at all
    byte_q = {};
    ack_dly = -1;
    run_op(21'h00055, 1'b1, 5);
    chk(l_fail && l_tmo && !l_pass, "R6 limit without ack", l_tmo, 1);
    chk(n_reads == 0, "R6 nothing acknowledged", n_reads, 0);

    // R6: steady mismatches until the limit
    dflt_byte = 8'h00;
    ack_dly = 1;
    run_op(21'h00066, 1'b1, 8);
    chk(l_fail && l_tmo, "R6 limit with mismatches", l_tmo, 1);

    // R6: zero limit, acknowledge in cycle 0 wins
    byte_q = {8'h80, 8'h3C};
    ack_dly = 0;
    run_op(21'h00099, 1'b1, 0);
    chk(l_pass && !l_tmo, "R6 ack precedes zero limit", l_pass, 1);
    chk(l_data == 8'h3C && n_reads == 2, "R6 zero limit data", l_data, 8'h3C);

    // R7: start while busy is ignored
    begin
      int d0;
      d0 = n_done;
      byte_q = {8'h80, 8'h00, 8'h11};
      ack_dly = 3;
      n_reads = 0;
      pulse_start(21'h0ABCD, 1'b0, 50);
      repeat (2) @(negedge clk);
      pulse_start(21'h15555, 1'b1, 0);
      wait_done(d0);
      chk(l_pass && !l_tmo, "R7 original poll completes", l_pass, 1);
      chk(l_data == 8'h11, "R7 original data", l_data, 8'h11);
      chk(rd_addr_o == 21'h0ABCD, "R7 address kept", rd_addr_o, 21'h0ABCD);
    end

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule